// File: doc/BRIEF.md
# Test Control Sequencer

This block is the top-level sequencer of a test-controller board. A host reaches it through a small register bus. It writes commands into a self-clearing instruction register at address 0 and reads the current test state from a status register at address 1. Each test run starts the same way. The sequencer first shifts a configuration word into an external clock generator over a slow serial link that it derives from its own clock. Only after that does it enable the scan engine, which then runs until it reports completion or until the host aborts it.

There are five states. IDLE is entered at reset. PROG_CLK serialises the configuration word and then the load strobe. RUNNING holds the scan engine enabled. ENDED is reached after normal completion and STOPPED after an abort. The transitions are:

- IDLE to PROG_CLK on a start command.
- PROG_CLK to RUNNING when the shifter finishes.
- PROG_CLK to STOPPED on a stop command.
- RUNNING to ENDED when the scan engine reports done.
- RUNNING to STOPPED on a stop command.
- ENDED or STOPPED back to PROG_CLK on a restart command.

Every other command is ignored in every state.

Top module: `test_seq_ctrl`

## Requirements
- R1: While reset is active and after it is released, status reads 0 (IDLE), and gen_sclk, gen_sdata, gen_load, scan_run and scan_abort are all low.
- R2: A write to address 0 places a command in the instruction register. The codes are 0 none, 1 start, 2 stop and 3 restart. The command can be read back at address 0 for exactly one cycle, after which the register reads 0. A write with any bit above bit 1 set is treated as no command.
- R3: Address 1 reads the state code in bits 2:0, with zeros above. The codes are IDLE=0, PROG_CLK=1, RUNNING=2, ENDED=3 and STOPPED=4.
- R4: In IDLE, a start command moves the state to PROG_CLK on the edge after the one that wrote it. Stop, restart, no command and scan_done leave the state in IDLE.
- R5: In PROG_CLK, the configuration word is sent MSB first, one bit per slow period of 2*CLK_DIV cycles. gen_sdata holds the bit for the whole period. gen_sclk is low for the first CLK_DIV cycles of the period and high for the last CLK_DIV cycles.
- R6: After the last bit, gen_load is high and gen_sclk is low for exactly one slow period. The state then becomes RUNNING, so PROG_CLK lasts (CFG_BITS+1)*2*CLK_DIV cycles.
- R7: scan_run is high exactly while the state is RUNNING. scan_done in RUNNING moves the state to ENDED on that edge.
- R8: A stop command in PROG_CLK or RUNNING moves the state to STOPPED. In RUNNING, scan_abort is high during the cycle the stop command is held. Stop takes priority over a simultaneous scan_done or shifter completion.
- R9: Start and restart commands in PROG_CLK or RUNNING are ignored.
- R10: In ENDED or STOPPED, a restart command returns the state to PROG_CLK and the full configuration frame is sent again. A start command in those states is ignored.
- R11: The configuration word is captured on the edge that enters PROG_CLK. Changes to cfg_word after that edge do not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 instruction, 1 status |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for the selected register |
| cfg_word | input | CFG_BITS | Clock-generator configuration word |
| gen_sclk | output | 1 | Slow serial clock to the clock generator |
| gen_sdata | output | 1 | Serial configuration data |
| gen_load | output | 1 | Load strobe after the last bit |
| scan_run | output | 1 | Scan engine enable |
| scan_abort | output | 1 | One-cycle abort pulse to the scan engine |
| scan_done | input | 1 | Scan engine completion |

## Verification
The assertions check the following on every cycle:

- The state only leaves through the transitions listed above.
- The scan engine is never enabled while the shifter is active.
- RUNNING is only entered on a shifter completion.
- Serial data stays still while the slow clock is high.
- The load strobe never overlaps a slow-clock high phase.
- A pending command self-clears.

Only the bench's scenarios can show the following:

- The exact bit order and period of the frame.
- The exact length of PROG_CLK.
- The capture of the configuration word when PROG_CLK is entered.
- The priority of stop over completion.
- That commands are ignored in each state.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PROG    = 3'd1,
        ST_RUN     = 3'd2,
        ST_ENDED   = 3'd3,
        ST_STOPPED = 3'd4
    } tseq_state_t;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_START   = 2'd1,
        CMD_STOP    = 2'd2,
        CMD_RESTART = 2'd3
    } tseq_cmd_t;

    localparam int STATE_W = 3;
    localparam int CMD_W   = 2;

endpackage

// File: rtl/tseq_regs.sv
module tseq_regs
    import tseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [STATE_W-1:0]  status,
    output tseq_cmd_t           cmd
);

    localparam int HI_W = DATA_W - CMD_W;

    logic      wr_instr;
    logic      hi_clear;
    tseq_cmd_t instr_q;

    assign wr_instr = host_wr && (host_addr == 1'b0);
    assign hi_clear = (host_wdata[DATA_W-1:CMD_W] == '0);

    // Self-clearing instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= CMD_NOP;
        end else if (wr_instr && hi_clear) begin
            instr_q <= tseq_cmd_t'(host_wdata[CMD_W-1:0]);
        end else begin
            instr_q <= CMD_NOP;
        end
    end

    assign cmd = instr_q;

    always_comb begin
        if (host_addr) begin
            host_rdata = {{(DATA_W-STATE_W){1'b0}}, status};
        end else begin
            host_rdata = {{HI_W{1'b0}}, instr_q};
        end
    end

    // R2
    instr_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_q != CMD_NOP) |=> ((instr_q == CMD_NOP) || $past(wr_instr)));

endmodule

// File: rtl/tseq_clkprog.sv
module tseq_clkprog #(
    parameter int CFG_BITS = 22,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CFG_BITS-1:0] cfg_word,
    output logic                sclk,
    output logic                sdata,
    output logic                sload,
    output logic                done
);

    localparam int PER   = 2 * CLK_DIV;
    localparam int DIV_W = (PER > 2) ? $clog2(PER) : 1;
    localparam int BIT_W = $clog2(CFG_BITS + 1);

    logic [DIV_W-1:0]    div_cnt;
    logic [BIT_W-1:0]    bit_cnt;
    logic [CFG_BITS-1:0] shreg;
    logic                load_phase;
    logic                per_end;

    assign load_phase = (bit_cnt == BIT_W'(CFG_BITS));
    assign per_end    = (div_cnt == DIV_W'(PER - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!en || done) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            if (!en) begin
                shreg <= cfg_word;
            end
        end else if (per_end) begin
            div_cnt <= '0;
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[CFG_BITS-2:0], 1'b0};
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign sclk  = en && !load_phase && (div_cnt >= DIV_W'(CLK_DIV));
    assign sdata = en && !load_phase && shreg[CFG_BITS-1];
    assign sload = en && load_phase;
    assign done  = en && load_phase && per_end;

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    // R6
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sload |-> !sclk);

    // R6
    load_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sload) |-> $past(sclk));

endmodule

// File: rtl/tseq_fsm.sv
module tseq_fsm
    import tseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  tseq_cmd_t    cmd,
    input  logic         prog_done,
    input  logic         scan_done,
    output tseq_state_t  state,
    output logic         shift_en,
    output logic         scan_run,
    output logic         scan_abort
);

    tseq_state_t state_q;
    tseq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_START) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (cmd == CMD_STOP)  state_d = ST_STOPPED;
                else if (prog_done)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cmd == CMD_STOP)  state_d = ST_STOPPED;
                else if (scan_done)   state_d = ST_ENDED;
            end
            ST_ENDED, ST_STOPPED: begin
                if (cmd == CMD_RESTART) state_d = ST_PROG;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_en   = (state_q == ST_PROG);
        scan_run   = (state_q == ST_RUN);
        scan_abort = (state_q == ST_RUN) && (cmd == CMD_STOP);
    end

    assign state = state_q;

    // R4
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_PROG));

    // R7
    run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=>
            (state_q == ST_RUN || state_q == ST_ENDED || state_q == ST_STOPPED));

    // R10
    term_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENDED || state_q == ST_STOPPED) |=>
            (state_q == $past(state_q) || state_q == ST_PROG));

    // R6
    prog_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_run) |-> $past(prog_done));

    // R7
    excl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scan_run, shift_en}));

endmodule

// File: rtl/test_seq_ctrl.sv
module test_seq_ctrl
    import tseq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CFG_BITS = 22,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [CFG_BITS-1:0] cfg_word,
    output logic                gen_sclk,
    output logic                gen_sdata,
    output logic                gen_load,
    output logic                scan_run,
    output logic                scan_abort,
    input  logic                scan_done
);

    tseq_cmd_t   cmd;
    tseq_state_t state;
    logic        shift_en;
    logic        prog_done;

    tseq_regs #(.DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .status     (state),
        .cmd        (cmd)
    );

    tseq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .prog_done  (prog_done),
        .scan_done  (scan_done),
        .state      (state),
        .shift_en   (shift_en),
        .scan_run   (scan_run),
        .scan_abort (scan_abort)
    );

    tseq_clkprog #(.CFG_BITS(CFG_BITS), .CLK_DIV(CLK_DIV)) prog_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (shift_en),
        .cfg_word (cfg_word),
        .sclk     (gen_sclk),
        .sdata    (gen_sdata),
        .sload    (gen_load),
        .done     (prog_done)
    );

    // R8
    abort_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_abort |=> (state == ST_STOPPED));

endmodule

// File: tb/test_seq_ctrl_tb.sv
module test_seq_ctrl_tb_top;

    localparam int DATA_W   = 8;
    localparam int CFG_BITS = 22;
    localparam int CLK_DIV  = 4;
    localparam int PER      = 2 * CLK_DIV;
    localparam int PROG_LEN = (CFG_BITS + 1) * PER;

    // {cmd[13:12], done[11], wait[10:3], expected status[2:0]}
    localparam int NVEC = 19;
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {2'd2, 1'b0, 8'd1,   3'd0},  // R4 stop ignored in IDLE
        {2'd3, 1'b0, 8'd1,   3'd0},  // R4 restart ignored in IDLE
        {2'd0, 1'b1, 8'd1,   3'd0},  // R4 done ignored in IDLE
        {2'd1, 1'b0, 8'd1,   3'd1},  // R4 start -> PROG_CLK
        {2'd1, 1'b0, 8'd1,   3'd1},  // R9 start ignored in PROG_CLK
        {2'd0, 1'b0, 8'd180, 3'd1},  // R6 last cycle of PROG_CLK
        {2'd0, 1'b0, 8'd0,   3'd2},  // R6 first cycle of RUNNING
        {2'd1, 1'b0, 8'd1,   3'd2},  // R9 start ignored in RUNNING
        {2'd0, 1'b1, 8'd0,   3'd3},  // R7 done -> ENDED
        {2'd1, 1'b0, 8'd1,   3'd3},  // R10 start ignored in ENDED
        {2'd3, 1'b0, 8'd1,   3'd1},  // R10 restart -> PROG_CLK
        {2'd2, 1'b0, 8'd1,   3'd4},  // R8 stop in PROG_CLK
        {2'd3, 1'b0, 8'd1,   3'd1},  // R10 restart from STOPPED
        {2'd0, 1'b0, 8'd183, 3'd2},  // R6 programming complete
        {2'd2, 1'b0, 8'd1,   3'd4},  // R8 stop in RUNNING
        {2'd3, 1'b0, 8'd1,   3'd1},  // R10 restart from STOPPED
        {2'd3, 1'b0, 8'd183, 3'd2},  // R9 restart ignored in PROG_CLK
        {2'd3, 1'b0, 8'd1,   3'd2},  // R9 restart ignored in RUNNING
        {2'd1, 1'b0, 8'd1,   3'd2}   // R9 start ignored in RUNNING
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                host_wr = 1'b0;
    logic                host_addr = 1'b0;
    logic [DATA_W-1:0]   host_wdata = '0;
    logic [DATA_W-1:0]   host_rdata;
    logic [CFG_BITS-1:0] cfg_word = '0;
    logic                gen_sclk, gen_sdata, gen_load;
    logic                scan_run, scan_abort;
    logic                scan_done = 1'b0;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    test_seq_ctrl #(.DATA_W(DATA_W), .CFG_BITS(CFG_BITS), .CLK_DIV(CLK_DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cfg_word   (cfg_word),
        .gen_sclk   (gen_sclk),
        .gen_sdata  (gen_sdata),
        .gen_load   (gen_load),
        .scan_run   (scan_run),
        .scan_abort (scan_abort),
        .scan_done  (scan_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic read_status(output logic [DATA_W-1:0] v);
        host_addr = 1'b1;
        #1;
        v = host_rdata;
        host_addr = 1'b0;
    endtask

    task automatic step(input logic [1:0] cmd, input logic dn, input int w,
                        input logic [2:0] exp, input string req);
        logic [DATA_W-1:0] v;
        host_wr    = (cmd != 2'd0);
        host_addr  = 1'b0;
        host_wdata = DATA_W'(cmd);
        scan_done  = dn;
        @(posedge clk);
        @(negedge clk);
        host_wr    = 1'b0;
        host_wdata = '0;
        scan_done  = 1'b0;
        repeat (w) @(negedge clk);
        read_status(v);
        chk(req, 32'(v), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [CFG_BITS-1:0] frame;
        int e_sclk, e_sdata, e_load;

        // R1 reset state
        repeat (3) @(negedge clk);
        read_status(v);
        chk("R1 status in reset", 32'(v), 32'd0);
        chk("R1 outputs in reset", 32'({gen_sclk, gen_sdata, gen_load, scan_run, scan_abort}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_status(v);
        chk("R3 IDLE code after reset", 32'(v), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13:12], VEC[i][11], int'(VEC[i][10:3]), VEC[i][2:0],
                 $sformatf("R3 vector %0d", i));
        end

        // R7 scan_run tracks RUNNING
        chk("R7 scan_run in RUNNING", 32'(scan_run), 32'd1);

        // R8 stop wins over simultaneous done; abort pulse
        host_wr = 1'b1; host_wdata = 8'd2;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        chk("R8 abort pulse", 32'(scan_abort), 32'd1);
        scan_done = 1'b1;
        @(posedge clk); @(negedge clk);
        scan_done = 1'b0;
        read_status(v);
        chk("R8 stop priority", 32'(v), 32'd4);
        chk("R8 abort cleared", 32'({scan_abort, scan_run}), 32'd0);

        // R2 instruction readback and self-clear
        host_wr = 1'b1; host_wdata = 8'd2;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        chk("R2 instruction readback", 32'(host_rdata), 32'd2);
        @(negedge clk);
        chk("R2 instruction self-clear", 32'(host_rdata), 32'd0);
        host_wr = 1'b1; host_wdata = 8'h43;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        chk("R2 upper bits void command", 32'(host_rdata), 32'd0);
        @(negedge clk);
        read_status(v);
        chk("R2 upper bits no effect", 32'(v), 32'd4);

        // R5 R6 R11 full frame after restart
        frame = 22'h2B5A3C;
        cfg_word = frame;
        host_wr = 1'b1; host_wdata = 8'd3;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        e_sclk = 0; e_sdata = 0; e_load = 0;
        for (int c = 0; c < PROG_LEN; c++) begin
            @(negedge clk);
            if (c == 1) cfg_word = ~frame;
            if (c < CFG_BITS * PER) begin
                if (gen_sclk !== ((c % PER) >= CLK_DIV)) e_sclk++;
                if (gen_sdata !== frame[CFG_BITS - 1 - c / PER]) e_sdata++;
                if (gen_load !== 1'b0) e_load++;
            end else begin
                if (gen_load !== 1'b1 || gen_sclk !== 1'b0) e_load++;
            end
        end
        chk("R5 slow clock shape", 32'(e_sclk), 32'd0);
        chk("R11 captured word sent MSB first", 32'(e_sdata), 32'd0);
        chk("R6 load strobe one period", 32'(e_load), 32'd0);
        @(negedge clk);
        read_status(v);
        chk("R6 RUNNING after load", 32'(v), 32'd2);
        chk("R7 scan_run after programming", 32'({scan_run, gen_load}), 32'd2);

        // R1 reset mid-test
        rst_n = 1'b0;
        #1;
        read_status(v);
        chk("R1 reset mid-test", 32'(v), 32'd0);
        chk("R1 outputs after mid reset", 32'({scan_run, gen_sclk, gen_load}), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule